// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a floating-point conditional test holds. A request carries a 6-bit predicate code and the current 32-bit floating-point status word. The block reads the four condition bits held in that word (negative, zero, infinity, not-a-number) and applies the test the code selects. One clock later it returns four things: the true/false outcome, a flag for a code outside the legal range, the rewritten status word, and a trap indication.

Each code belongs to one of two groups. The IEEE-aware tests never signal. The signalling tests raise the branch-on-unordered exception whenever the NaN condition is present. A code can also request the complement of one of eight base tests. Before the test runs, the exception byte of the status word is wiped, and only the unordered bit can be raised again. A caller-supplied enable mask is compared against the returned exception byte to produce a trap flag. The block computes that flag but does not act on it.

A two-state controller sequences the block. In ST_IDLE there is no fresh result. A request seen in ST_IDLE takes the transition GO_DONE into ST_DONE, and a request seen in ST_DONE takes STAY_DONE and remains there. With no request, ST_DONE takes the transition GO_IDLE back to ST_IDLE, and ST_IDLE holds on IDLE_HOLD. The output `res_valid` is high exactly while the controller is in ST_DONE.

Top module: `fpcc_eval`

## Requirements
- R1: When `req_valid` is high at a rising edge, the outputs change at that edge and `res_valid` is high for the following cycle. `res_valid` is low whenever the preceding edge saw no request.
- R2: A predicate with bit 5 set (value 0x20 or above) produces the following: `res_illegal`=1, `res_true`=0, `res_trap`=0, and `res_status` equal to the incoming status word unchanged.
- R3: In the status word, N is bit 27, Z is bit 26, I is bit 25 and NaN is bit 24. For a legal predicate with bit 3 clear, bits 2..0 pick the base test, and the I bit affects none of the tests:
  - 0: never true.
  - 1: Z.
  - 2: none of NaN, Z and N.
  - 3: Z, or neither NaN nor N.
  - 4: N with both NaN and Z clear.
  - 5: Z, or N with NaN clear.
  - 6: NaN and Z both clear.
  - 7: NaN clear.
- R4: When predicate bit 3 is set, the base test index is the bitwise complement of bits 2..0, and `res_true` is the inverse of that base test.
- R5: Predicate bit 4 marks a signalling test. When that test sees NaN set, the returned status word has bit 15 (branch-on-unordered) set. Otherwise bit 15 is returned as 0. Bit 4 does not change `res_true`.
- R6: For a legal predicate, bits 14..8 of `res_status` are 0, and every bit outside 15..8 equals the incoming word.
- R7: For a legal predicate, `res_trap` is 1 exactly when some bit k of `trap_enable` (0..7) and bit 8+k of `res_status` are both set.
- R8: Reset clears `res_valid`, `res_true`, `res_illegal`, `res_trap` and `res_status` to 0.
- R9: Without a request, `res_true`, `res_illegal`, `res_trap` and `res_status` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one evaluation per high cycle |
| req_pred | input | 6 | Predicate code |
| req_status | input | 32 | Incoming floating-point status word |
| trap_enable | input | 8 | Exception enable mask; bit k guards status bit 8+k |
| res_valid | output | 1 | High in the cycle after a request |
| res_true | output | 1 | Outcome of the predicate |
| res_illegal | output | 1 | Predicate code out of range |
| res_status | output | 32 | Status word after clearing and updating |
| res_trap | output | 1 | An enabled exception is present in `res_status` |

## Verification
The properties compare each result with the request inputs one edge earlier through `$past`. They therefore assume that `req_pred`, `req_status` and `trap_enable` hold known, 2-state values at every edge where `req_valid` is high, and that a request observed at the first edge after reset is a real request. The bench drives all request inputs on the falling clock edge, gives them defined values before reset is released, and keeps `req_valid` low until it has set them. Legal predicates are exercised with the exception byte of the incoming word fully set, so that the clearing rule is visible in every result.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
    // Condition-code bit positions in the status word
    localparam int CC_N   = 27;
    localparam int CC_Z   = 26;
    localparam int CC_I   = 25;
    localparam int CC_NAN = 24;
    // Exception byte
    localparam int EXC_LO   = 8;
    localparam int EXC_W    = 8;
    localparam int EXC_HI   = EXC_LO + EXC_W - 1;
    localparam int EXC_BSUN = EXC_HI;
    // Predicate field positions
    localparam int PF_ILLEGAL = 5;
    localparam int PF_SIGNAL  = 4;
    localparam int PF_INVERT  = 3;
    localparam int BASE_W     = 3;

    typedef enum logic [BASE_W-1:0] {
        BT_NEVER   = 3'd0,
        BT_EQ      = 3'd1,
        BT_GT      = 3'd2,
        BT_GE      = 3'd3,
        BT_LT      = 3'd4,
        BT_LE      = 3'd5,
        BT_GL      = 3'd6,
        BT_ORDERED = 3'd7
    } base_test_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ctrl_state_t;

    typedef struct packed {
        logic       illegal;
        logic       signalling;
        logic       invert;
        base_test_t base;
    } pred_fields_t;
endpackage

// File: rtl/fpcc_decode.sv
module fpcc_decode
    import fpcc_pkg::*;
#(
    parameter int PRED_W = 6
) (
    input  logic [PRED_W-1:0] pred,
    output pred_fields_t      fields
);
    logic [BASE_W-1:0] low_sel;

    always_comb begin
        low_sel           = pred[BASE_W-1:0];
        fields.illegal    = |pred[PRED_W-1:PF_ILLEGAL];
        fields.signalling = pred[PF_SIGNAL];
        fields.invert     = pred[PF_INVERT];
        // A complemented code names the complement of its low bits
        fields.base       = base_test_t'(pred[PF_INVERT] ? ~low_sel : low_sel);
    end
endmodule

// File: rtl/fpcc_test.sv
module fpcc_test
    import fpcc_pkg::*;
(
    input  base_test_t base,
    input  logic       cc_n,
    input  logic       cc_z,
    input  logic       cc_nan,
    output logic       hit
);
    always_comb begin
        unique case (base)
            BT_NEVER:   hit = 1'b0;
            BT_EQ:      hit = cc_z;
            BT_GT:      hit = !(cc_nan || cc_z || cc_n);
            BT_GE:      hit = cc_z || !(cc_nan || cc_n);
            BT_LT:      hit = cc_n && !cc_nan && !cc_z;
            BT_LE:      hit = cc_z || (cc_n && !cc_nan);
            BT_GL:      hit = !(cc_nan || cc_z);
            BT_ORDERED: hit = !cc_nan;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpcc_status.sv
module fpcc_status
    import fpcc_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic [STAT_W-1:0] status_in,
    input  logic              signalling,
    output logic [STAT_W-1:0] status_out,
    output logic              unordered
);
    always_comb begin
        unordered                   = signalling && status_in[CC_NAN];
        status_out                  = status_in;
        status_out[EXC_HI:EXC_LO]   = '0;
        status_out[EXC_BSUN]        = unordered;
    end
endmodule

// File: rtl/fpcc_eval.sv
module fpcc_eval
    import fpcc_pkg::*;
#(
    parameter int PRED_W = 6,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PRED_W-1:0] req_pred,
    input  logic [STAT_W-1:0] req_status,
    input  logic [EXC_W-1:0]  trap_enable,
    output logic              res_valid,
    output logic              res_true,
    output logic              res_illegal,
    output logic [STAT_W-1:0] res_status,
    output logic              res_trap
);
    ctrl_state_t       state_q, state_d;
    pred_fields_t      fields;
    logic              base_hit;
    logic [STAT_W-1:0] upd_status;
    logic              unordered;

    fpcc_decode #(.PRED_W(PRED_W)) u_decode (
        .pred   (req_pred),
        .fields (fields)
    );

    fpcc_test u_test (
        .base   (fields.base),
        .cc_n   (req_status[CC_N]),
        .cc_z   (req_status[CC_Z]),
        .cc_nan (req_status[CC_NAN]),
        .hit    (base_hit)
    );

    fpcc_status #(.STAT_W(STAT_W)) u_status (
        .status_in  (req_status),
        .signalling (fields.signalling),
        .status_out (upd_status),
        .unordered  (unordered)
    );

    // Controller: next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_DONE : ST_IDLE;   // GO_DONE / IDLE_HOLD
            ST_DONE: state_d = req_valid ? ST_DONE : ST_IDLE;   // STAY_DONE / GO_IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    // Controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign res_valid = (state_q == ST_DONE);

    // Result registers, loaded on each request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_true    <= 1'b0;
            res_illegal <= 1'b0;
            res_status  <= '0;
            res_trap    <= 1'b0;
        end else if (req_valid) begin
            if (fields.illegal) begin
                res_true    <= 1'b0;
                res_illegal <= 1'b1;
                res_status  <= req_status;
                res_trap    <= 1'b0;
            end else begin
                res_true    <= base_hit ^ fields.invert;
                res_illegal <= 1'b0;
                res_status  <= upd_status;
                res_trap    <= |(upd_status[EXC_HI:EXC_LO] & trap_enable);
            end
        end
    end

    // Checks next to the logic they guard
    assert_valid_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(req_valid))
        else $error("R1: res_valid does not track request");

    assert_illegal_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_illegal) |-> (!res_true && !res_trap && res_status == $past(req_status)))
        else $error("R2: illegal result wrong");

    assert_unordered_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_illegal) |->
            (res_status[EXC_BSUN] == ($past(req_pred[PF_SIGNAL]) && $past(req_status[CC_NAN]))))
        else $error("R5: unordered bit wrong");

    assert_exc_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_illegal) |->
            (res_status[EXC_HI-1:EXC_LO] == '0 && res_status[CC_N:CC_NAN] == $past(req_status[CC_N:CC_NAN])))
        else $error("R6: status not cleared or condition bits altered");

    assert_trap_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_trap) |-> (|(res_status[EXC_HI:EXC_LO] & $past(trap_enable))))
        else $error("R7: trap without enabled exception");

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> ($stable(res_status) && $stable(res_true) && $stable(res_trap)))
        else $error("R9: outputs moved without request");
endmodule

// File: tb/tb_fpcc_eval.sv
module tb_fpcc_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_pred = '0;
    logic [31:0] req_status = '0;
    logic [7:0]  trap_enable = '0;
    logic        res_valid, res_true, res_illegal, res_trap;
    logic [31:0] res_status;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    fpcc_eval dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pred(req_pred),
        .req_status(req_status), .trap_enable(trap_enable), .res_valid(res_valid),
        .res_true(res_true), .res_illegal(res_illegal), .res_status(res_status),
        .res_trap(res_trap)
    );

    // {pred[5:0], cc {N,Z,I,NaN}, expected true, expected unordered}
    localparam int NV = 22;
    localparam logic [11:0] VEC [NV] = '{
        {6'h01, 4'b0100, 1'b1, 1'b0},
        {6'h01, 4'b0000, 1'b0, 1'b0},
        {6'h02, 4'b0000, 1'b1, 1'b0},
        {6'h02, 4'b1000, 1'b0, 1'b0},
        {6'h02, 4'b0010, 1'b1, 1'b0},
        {6'h03, 4'b0100, 1'b1, 1'b0},
        {6'h03, 4'b0001, 1'b0, 1'b0},
        {6'h04, 4'b1000, 1'b1, 1'b0},
        {6'h04, 4'b1001, 1'b0, 1'b0},
        {6'h05, 4'b1000, 1'b1, 1'b0},
        {6'h05, 4'b0001, 1'b0, 1'b0},
        {6'h06, 4'b0000, 1'b1, 1'b0},
        {6'h07, 4'b0001, 1'b0, 1'b0},
        {6'h00, 4'b0100, 1'b0, 1'b0},
        {6'h0F, 4'b0001, 1'b1, 1'b0},
        {6'h0E, 4'b0100, 1'b0, 1'b0},
        {6'h08, 4'b0001, 1'b1, 1'b0},
        {6'h0D, 4'b0000, 1'b0, 1'b0},
        {6'h12, 4'b0000, 1'b1, 1'b0},
        {6'h11, 4'b0001, 1'b0, 1'b1},
        {6'h1F, 4'b0001, 1'b1, 1'b1},
        {6'h19, 4'b0100, 1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request on a falling edge; return at the next falling edge
    task automatic request(input logic [5:0] p, input logic [31:0] s, input logic [7:0] en);
        req_pred = p; req_status = s; trap_enable = en; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #4_000_000;
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(res_valid == 0 && res_true == 0 && res_illegal == 0 && res_trap == 0,
              "R8 flags in reset", {28'd0, res_valid, res_true, res_illegal, res_trap}, 32'd0);
        check(res_status == 32'd0, "R8 status in reset", res_status, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 0, "R1 idle after reset", {31'd0, res_valid}, 32'd0);

        // Table walk: R3 / R4 / R5 / R6 / R7
        for (int i = 0; i < NV; i++) begin
            logic [5:0]  p;
            logic [3:0]  cc;
            logic [31:0] sin, sexp;
            string       tag;
            p   = VEC[i][11:6];
            cc  = VEC[i][5:2];
            sin = {4'h5, cc, 8'h3C, 8'hFF, 8'hA8};
            sexp = {4'h5, cc, 8'h3C, VEC[i][0], 7'd0, 8'hA8};
            if (p[4])      tag = "R5";
            else if (p[3]) tag = "R4";
            else           tag = "R3";
            request(p, sin, 8'h80);
            check(res_valid == 1'b1, "R1 valid after request", {31'd0, res_valid}, 32'd1);
            check(res_true == VEC[i][1], tag, {31'd0, res_true}, {31'd0, VEC[i][1]});
            check(res_status == sexp, "R6 status update", res_status, sexp);
            check(res_trap == VEC[i][0], "R7 trap with unordered enabled", {31'd0, res_trap}, {31'd0, VEC[i][0]});
            check(res_illegal == 1'b0, "R2 legal code", {31'd0, res_illegal}, 32'd0);
        end

        // R9: no request, outputs hold, valid drops
        snap = res_status;
        @(negedge clk);
        check(res_valid == 1'b0, "R1 valid drops", {31'd0, res_valid}, 32'd0);
        check(res_status == snap && res_true == 1'b1, "R9 hold", res_status, snap);

        // R2: illegal codes
        request(6'h20, 32'h0F00_FFF8, 8'hFF);
        check(res_illegal == 1'b1 && res_true == 1'b0 && res_trap == 1'b0,
              "R2 code 0x20 flags", {29'd0, res_illegal, res_true, res_trap}, 32'd4);
        check(res_status == 32'h0F00_FFF8, "R2 code 0x20 status", res_status, 32'h0F00_FFF8);
        request(6'h3F, 32'h0100_0000, 8'hFF);
        check(res_illegal == 1'b1 && res_true == 1'b0, "R2 code 0x3F",
              {30'd0, res_illegal, res_true}, 32'd2);
        check(res_status == 32'h0100_0000, "R2 code 0x3F status", res_status, 32'h0100_0000);

        // R7: unordered raised but not enabled
        request(6'h11, 32'h0100_FF00, 8'h7F);
        check(res_trap == 1'b0, "R7 masked trap", {31'd0, res_trap}, 32'd0);
        check(res_status == 32'h0100_8000, "R5 unordered raised", res_status, 32'h0100_8000);
        // R5: aware test on NaN never raises unordered
        request(6'h01, 32'h0100_FF00, 8'hFF);
        check(res_status == 32'h0100_0000 && res_trap == 1'b0, "R5 aware no unordered",
              res_status, 32'h0100_0000);

        // R1: back-to-back requests
        req_pred = 6'h01; req_status = 32'h0400_0000; trap_enable = 8'h00; req_valid = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b1 && res_true == 1'b1, "R1 back-to-back first",
              {30'd0, res_valid, res_true}, 32'd3);
        req_pred = 6'h0E;
        @(negedge clk);
        req_valid = 1'b0;
        check(res_valid == 1'b1 && res_true == 1'b0, "R1 back-to-back second",
              {30'd0, res_valid, res_true}, 32'd2);

        // R8: reset after a result
        request(6'h0F, 32'h0800_0000, 8'h00);
        rst_n = 1'b0;
        #2;
        check(res_valid == 0 && res_true == 0 && res_status == 32'd0, "R8 reset clears",
              res_status, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule